// File: doc/BRIEF.md
# Flash Erase Sequencer with Granule Selection

This block turns a single erase request, given as a start address and a byte length, into the sequence of serial flash transactions that clears that range. At every step it looks at the current address and the bytes still to clear. It then issues the widest erase the device offers that starts on a matching boundary and does not run past the end of the range. The device offers 64 KB, 32 KB and 4 KB erases.

Every erase is wrapped in the same handshake with the flash. First a write-enable frame is sent. Status is then read until the write-enable latch reports set, and only then is the erase frame sent. After the erase, status is read until the busy flag drops. Each status loop has a bounded number of attempts. If a loop runs out, the request ends with a device error. Requests that are not sector-aligned, or that would run past the end of the device, are refused before any serial traffic.

The block drives a byte-level serial engine. It pulses a start strobe with a byte and waits for a completion strobe that returns the received byte. It also owns the active-low chip select that frames each transaction.

Top module: `erase_sequencer`

## Requirements
- R1: Each step issues opcode 0xD8 (64 KB) when the remaining length is at least 65536 and the current address is a multiple of 65536. Otherwise it issues 0x52 (32 KB) under the same two tests at 32768. Otherwise it issues 0x20 (4 KB). After each step the address grows by the chosen size and the remaining length shrinks by it.
- R2: The erase frame is exactly four bytes inside one low period of `spi_cs_n`: the opcode, then address bits 23:16, 15:8 and 7:0. The write-enable frame is the single byte 0x06. A status read is the two bytes 0x05 and 0x00, and the second returned byte is the status. `spi_cs_n` is high whenever no frame is in progress, and `xfer_start` only pulses while it is low.
- R3: No erase frame is sent until a write-enable frame has been sent and a later status read has returned bit 1 (write-enable latch) set.
- R4: After an erase frame, status is read repeatedly until bit 0 (write in progress) reads clear. No further write-enable or erase frame is sent before that.
- R5: A status loop that sees no success in `POLL_LIMIT` consecutive reads ends the request with `err_code` = 2. No further frames follow.
- R6: A request whose address or length has any of bits 11:0 set, or whose address plus length exceeds `DEV_BYTES`, gets `done` with `err_code` = 1 on the cycle after acceptance. Such a request causes no serial frame, and `cmd_count` reads 0.
- R7: On success, `done` pulses for exactly one cycle with `err_code` = 0. `cmd_count` then equals the number of erase frames issued for the request.
- R8: `busy` is high from acceptance until `done`. A `req_valid` seen while busy is ignored.
- R9: A request with length 0 completes with `done` and `err_code` = 0 on the next cycle, with no frames and `cmd_count` = 0.
- R10: After reset, `spi_cs_n` = 1 and `busy`, `done`, `xfer_start` and `cmd_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W+1 | Byte length to erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 bad parameters, 2 device timeout; valid with done |
| cmd_count | output | CNT_W | Erase frames issued for the current request |
| spi_cs_n | output | 1 | Active-low flash chip select |
| xfer_start | output | 1 | Starts one byte transfer |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Byte transfer finished |
| xfer_rx | input | 8 | Byte received, valid with xfer_done |

## Verification
A wrong granule choice or a wrong address advance shows up at the very next erase frame. That frame carries the wrong opcode or address, and the scoreboard flags it when chip select rises. A status loop that exits too early shows up as a write-enable or erase frame arriving while the model still reports the latch clear or the flash busy, within one frame of the mistake. A miscounted poll limit or a broken parameter check shows up at the `done` pulse. It appears either as a wrong `err_code` or `cmd_count`, or as frames the request should never have produced.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;

  // granules from widest to narrowest; order is the selection priority
  localparam int NUM_GRAN = 3;
  localparam int GRAN_LOG2 [NUM_GRAN] = '{16, 15, 12};
  localparam logic [7:0] GRAN_OP [NUM_GRAN] = '{8'hD8, 8'h52, 8'h20};

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_PARAM  = 2'd1;
  localparam logic [1:0] ERR_DEVICE = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WREN,
    S_WEL,
    S_ERASE,
    S_WIP
  } seq_state_t;
endpackage

// File: rtl/erase_granule_pick.sv
module erase_granule_pick
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  rem,
  output logic [7:0]        opcode,
  output logic [LEN_W-1:0]  gsize
);
  logic [LEN_W-1:0] sz;
  logic             found;

  always_comb begin
    found  = 1'b0;
    opcode = GRAN_OP[NUM_GRAN-1];
    gsize  = LEN_W'(1) << GRAN_LOG2[NUM_GRAN-1];
    sz     = '0;
    for (int i = 0; i < NUM_GRAN; i++) begin
      sz = LEN_W'(1) << GRAN_LOG2[i];
      if (!found && rem >= sz && ((LEN_W'(cur_addr) & (sz - 1'b1)) == '0)) begin
        found  = 1'b1;
        opcode = GRAN_OP[i];
        gsize  = sz;
      end
    end
  end
endmodule

// File: rtl/erase_spi_framer.sv
module erase_spi_framer (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_go,
  input  logic [2:0]  nbytes,
  input  logic [31:0] payload,
  output logic        cs_n,
  output logic        xfer_start,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_done,
  input  logic [7:0]  xfer_rx,
  output logic [7:0]  rx_last,
  output logic        frame_done
);
  logic        active;
  logic [2:0]  left;
  logic [31:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      cs_n       <= 1'b1;
      xfer_start <= 1'b0;
      xfer_tx    <= '0;
      rx_last    <= '0;
      frame_done <= 1'b0;
      left       <= '0;
      sh         <= '0;
    end else begin
      xfer_start <= 1'b0;
      frame_done <= 1'b0;
      if (frame_go && !active) begin
        active     <= 1'b1;
        cs_n       <= 1'b0;
        xfer_tx    <= payload[31:24];
        sh         <= {payload[23:0], 8'h00};
        left       <= nbytes - 3'd1;
        xfer_start <= 1'b1;
      end else if (active && xfer_done) begin
        rx_last <= xfer_rx;
        if (left == 3'd0) begin
          active     <= 1'b0;
          cs_n       <= 1'b1;
          frame_done <= 1'b1;
        end else begin
          left       <= left - 3'd1;
          xfer_tx    <= sh[31:24];
          sh         <= {sh[23:0], 8'h00};
          xfer_start <= 1'b1;
        end
      end
    end
  end

  AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> !cs_n); // R2
endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DEV_BYTES  = 2097152,
  parameter int POLL_LIMIT = 10000,
  parameter int CNT_W      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [ADDR_W:0]     req_len,
  output logic                busy,
  output logic                done,
  output logic [1:0]          err_code,
  output logic [CNT_W-1:0]    cmd_count,
  output logic                spi_cs_n,
  output logic                xfer_start,
  output logic [7:0]          xfer_tx,
  input  logic                xfer_done,
  input  logic [7:0]          xfer_rx
);
  localparam int LEN_W     = ADDR_W + 1;
  localparam int SECT_LOG2 = GRAN_LOG2[NUM_GRAN-1];
  localparam int PC_W      = $clog2(POLL_LIMIT + 1);
  localparam int SUM_W     = LEN_W + 1;

  seq_state_t       state;
  logic             inflight;
  logic             frame_go;
  logic [2:0]       nbytes;
  logic [31:0]      payload;
  logic [7:0]       rx_last;
  logic             frame_done;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0] rem;
  logic [PC_W-1:0]  poll_cnt;
  logic             wel_ok;
  logic [7:0]       g_op;
  logic [LEN_W-1:0] g_size;
  logic             bad_req;

  assign bad_req = (req_addr[SECT_LOG2-1:0] != '0) ||
                   (req_len[SECT_LOG2-1:0] != '0) ||
                   ((SUM_W'(req_addr) + SUM_W'(req_len)) > SUM_W'(DEV_BYTES));

  erase_granule_pick #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_pick (
    .cur_addr (cur_addr),
    .rem      (rem),
    .opcode   (g_op),
    .gsize    (g_size)
  );

  erase_spi_framer u_framer (
    .clk        (clk),
    .rst        (rst),
    .frame_go   (frame_go),
    .nbytes     (nbytes),
    .payload    (payload),
    .cs_n       (spi_cs_n),
    .xfer_start (xfer_start),
    .xfer_tx    (xfer_tx),
    .xfer_done  (xfer_done),
    .xfer_rx    (xfer_rx),
    .rx_last    (rx_last),
    .frame_done (frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      inflight  <= 1'b0;
      frame_go  <= 1'b0;
      nbytes    <= '0;
      payload   <= '0;
      cur_addr  <= '0;
      rem       <= '0;
      poll_cnt  <= '0;
      wel_ok    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_code  <= ERR_NONE;
      cmd_count <= '0;
    end else begin
      done     <= 1'b0;
      frame_go <= 1'b0;
      if (state != S_IDLE && !inflight) begin
        inflight <= 1'b1;
        frame_go <= 1'b1;
        case (state)
          S_WREN:  begin nbytes <= 3'd1; payload <= {OP_WREN, 24'h0}; end
          S_ERASE: begin nbytes <= 3'd4; payload <= {g_op, 24'(cur_addr)}; end
          default: begin nbytes <= 3'd2; payload <= {OP_RDSR, 24'h0}; end
        endcase
      end
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            cmd_count <= '0;
            poll_cnt  <= '0;
            if (bad_req) begin
              done     <= 1'b1;
              err_code <= ERR_PARAM;
            end else if (req_len == '0) begin
              done     <= 1'b1;
              err_code <= ERR_NONE;
            end else begin
              busy     <= 1'b1;
              cur_addr <= req_addr;
              rem      <= req_len;
              state    <= S_WREN;
            end
          end
        end
        S_WREN: if (frame_done) begin
          inflight <= 1'b0;
          state    <= S_WEL;
        end
        S_WEL: if (frame_done) begin
          inflight <= 1'b0;
          if (rx_last[1]) begin
            poll_cnt <= '0;
            wel_ok   <= 1'b1;
            state    <= S_ERASE;
          end else if (poll_cnt == PC_W'(POLL_LIMIT - 1)) begin
            state    <= S_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            err_code <= ERR_DEVICE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        S_ERASE: if (frame_done) begin
          inflight  <= 1'b0;
          wel_ok    <= 1'b0;
          cmd_count <= cmd_count + 1'b1;
          state     <= S_WIP;
        end
        S_WIP: if (frame_done) begin
          inflight <= 1'b0;
          if (!rx_last[0]) begin
            poll_cnt <= '0;
            cur_addr <= cur_addr + ADDR_W'(g_size);
            rem      <= rem - g_size;
            if (rem == g_size) begin
              state    <= S_IDLE;
              busy     <= 1'b0;
              done     <= 1'b1;
              err_code <= ERR_NONE;
            end else begin
              state <= S_WREN;
            end
          end else if (poll_cnt == PC_W'(POLL_LIMIT - 1)) begin
            state    <= S_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            err_code <= ERR_DEVICE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ERASE_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst)
    (frame_go && payload[31:24] != OP_WREN && payload[31:24] != OP_RDSR) |-> wel_ok); // R3
  AST_GRANULE_FITS: assert property (@(posedge clk) disable iff (rst)
    (state == S_ERASE && frame_go) |->
      ((LEN_W'(cur_addr) & (g_size - 1'b1)) == '0 && g_size <= rem)); // R1
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < PC_W'(POLL_LIMIT)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && state == S_IDLE) |-> !xfer_start); // R6
endmodule

// File: tb/test_erase_sequencer.sv
`timescale 1ns/1ps
module test_erase_sequencer;
  localparam int ADDR_W = 24;
  localparam int PLIM   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ADDR_W:0]   req_len = '0;
  logic busy, done, spi_cs_n, xfer_start;
  logic [1:0] err_code;
  logic [15:0] cmd_count;
  logic [7:0] xfer_tx;
  logic xfer_done = 1'b0;
  logic [7:0] xfer_rx = 8'h00;

  always #2.5 clk = ~clk;

  erase_sequencer #(.ADDR_W(ADDR_W), .DEV_BYTES(2097152), .POLL_LIMIT(PLIM), .CNT_W(16))
  i_erase_sequencer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .done(done), .err_code(err_code), .cmd_count(cmd_count),
    .spi_cs_n(spi_cs_n), .xfer_start(xfer_start), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx)
  );

  int checks = 0;
  int failures = 0;
  int frames = 0;
  logic [31:0] expq [$];

  // flash model state
  logic wel = 1'b0, wip = 1'b0, wel_seen = 1'b0;
  logic never_wel = 1'b0, stuck_wip = 1'b0;
  int busy_left = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash responder and scoreboard monitor
  initial begin
    logic [7:0] fb [8];
    int nb = 0;
    int pend = 0;
    logic [7:0] resp = 8'h00;
    logic prev_cs = 1'b1;
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin xfer_done = 1'b1; xfer_rx = resp; end
      end
      if (xfer_start) begin
        if (nb < 8) fb[nb] = xfer_tx;
        resp = (nb == 1 && fb[0] == 8'h05) ? {6'b0, wel, wip} : 8'h00;
        if (nb == 1 && fb[0] == 8'h05 && wel) wel_seen = 1'b1;
        nb++;
        pend = 2;
      end
      if (prev_cs && !spi_cs_n) frames++;
      if (!prev_cs && spi_cs_n) begin
        if (fb[0] == 8'h06) begin
          chk(nb == 1, "R2 wren length", nb, 1);
          chk(!wip, "R4 wren while busy", {31'b0, wip}, 0);
          if (!never_wel) wel = 1'b1;
        end else if (fb[0] == 8'h05) begin
          chk(nb == 2, "R2 status length", nb, 2);
          if (wip && !stuck_wip) begin
            busy_left--;
            if (busy_left == 0) wip = 1'b0;
          end
        end else if (fb[0] == 8'hD8 || fb[0] == 8'h52 || fb[0] == 8'h20) begin
          chk(nb == 4, "R2 erase length", nb, 4);
          chk(wel_seen, "R3 erase without latch", {31'b0, wel_seen}, 1);
          chk(!wip, "R4 erase while busy", {31'b0, wip}, 0);
          if (expq.size() == 0) begin
            chk(1'b0, "R1 unexpected erase", {fb[0], fb[1], fb[2], fb[3]}, 0);
          end else begin
            logic [31:0] e;
            e = expq.pop_front();
            chk({fb[0], fb[1], fb[2], fb[3]} == e, "R1 erase command", {fb[0], fb[1], fb[2], fb[3]}, e);
          end
          wel = 1'b0; wel_seen = 1'b0; wip = 1'b1; busy_left = 3;
        end else begin
          chk(1'b0, "R2 unknown opcode", fb[0], 0);
        end
        nb = 0;
      end
      prev_cs = spi_cs_n;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic expect_cmds(input logic [31:0] a0, input logic [31:0] l0, output int n);
    logic [31:0] a, l;
    a = a0; l = l0; n = 0;
    while (l != 0) begin
      if (l >= 32'h10000 && a[15:0] == 0) begin expq.push_back({8'hD8, a[23:0]}); a += 32'h10000; l -= 32'h10000; end
      else if (l >= 32'h8000 && a[14:0] == 0) begin expq.push_back({8'h52, a[23:0]}); a += 32'h8000; l -= 32'h8000; end
      else begin expq.push_back({8'h20, a[23:0]}); a += 32'h1000; l -= 32'h1000; end
      n++;
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] l);
    @(negedge clk);
    req_addr = a[ADDR_W-1:0];
    req_len  = l[ADDR_W:0];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output logic got);
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_ok(input logic [31:0] a, input logic [31:0] l, input string tag);
    int n;
    logic got;
    expect_cmds(a, l, n);
    issue(a, l);
    chk(busy, {tag, " R8 busy"}, {31'b0, busy}, 1);
    wait_done(got);
    chk(got, {tag, " R7 done seen"}, {31'b0, got}, 1);
    chk(err_code == 2'd0, {tag, " R7 err ok"}, err_code, 0);
    chk(cmd_count == 16'(n), {tag, " R7 count"}, cmd_count, n);
    chk(expq.size() == 0, {tag, " R1 all commands seen"}, expq.size(), 0);
    @(negedge clk);
    chk(!done, {tag, " R7 single pulse"}, {31'b0, done}, 0);
    chk(!busy, {tag, " R8 busy cleared"}, {31'b0, busy}, 0);
  endtask

  task automatic run_reject(input logic [31:0] a, input logic [31:0] l, input logic [1:0] ec, input string tag);
    int f0;
    f0 = frames;
    issue(a, l);
    chk(done, {tag, " done next cycle"}, {31'b0, done}, 1);
    chk(err_code == ec, {tag, " err"}, err_code, ec);
    chk(cmd_count == 0, {tag, " count"}, cmd_count, 0);
    repeat (20) @(negedge clk);
    chk(frames == f0, {tag, " no frames"}, frames, f0);
  endtask

  initial begin
    int n, f0;
    logic got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(spi_cs_n, "R10 cs_n", {31'b0, spi_cs_n}, 1);
    chk(!busy && !done && !xfer_start, "R10 flags", {busy, done, xfer_start}, 0);
    chk(cmd_count == 0, "R10 count", cmd_count, 0);

    // R1 aligned 64K, then R8 ignored request during run
    expect_cmds(32'h0, 32'h10000, n);
    issue(32'h0, 32'h10000);
    repeat (10) @(negedge clk);
    chk(busy, "R8 busy mid run", {31'b0, busy}, 1);
    issue(32'h100000, 32'h1000);
    wait_done(got);
    chk(got && err_code == 0, "R8 first request completes", {30'b0, err_code}, 0);
    chk(cmd_count == 16'(n), "R8 ignored request adds nothing", cmd_count, n);
    chk(expq.size() == 0, "R8 queue drained", expq.size(), 0);
    repeat (30) @(negedge clk);
    chk(!busy, "R8 not restarted", {31'b0, busy}, 0);

    run_ok(32'h1000, 32'h11000, "R1 small then 32K");
    run_ok(32'h18000, 32'h30000, "R1 mixed 32K/64K");
    run_ok(32'h3000, 32'h2000, "R1 4K only");
    run_ok(32'h1F0000, 32'h10000, "R6 exact device end");

    run_reject(32'h0800, 32'h1000, 2'd1, "R6 misaligned addr");
    run_reject(32'h1000, 32'h0100, 2'd1, "R6 misaligned len");
    run_reject(32'h1F0000, 32'h20000, 2'd1, "R6 overrun");
    run_reject(32'h4000, 32'h0, 2'd0, "R9 zero length");

    // R5 latch never sets
    never_wel = 1'b1;
    f0 = frames;
    issue(32'h0, 32'h1000);
    wait_done(got);
    chk(got && err_code == 2'd2, "R5 latch timeout err", {30'b0, err_code}, 2);
    chk(cmd_count == 0, "R5 latch timeout count", cmd_count, 0);
    chk(frames - f0 == 1 + PLIM, "R5 latch poll attempts", frames - f0, 1 + PLIM);
    repeat (40) @(negedge clk);
    chk(frames - f0 == 1 + PLIM, "R5 quiet after abort", frames - f0, 1 + PLIM);
    never_wel = 1'b0;

    // R5 busy flag stuck
    stuck_wip = 1'b1;
    expect_cmds(32'h8000, 32'h8000, n);
    f0 = frames;
    issue(32'h8000, 32'h8000);
    wait_done(got);
    chk(got && err_code == 2'd2, "R5 busy timeout err", {30'b0, err_code}, 2);
    chk(cmd_count == 1, "R5 busy timeout count", cmd_count, 1);
    chk(frames - f0 == 3 + PLIM, "R5 busy poll attempts", frames - f0, 3 + PLIM);
    repeat (40) @(negedge clk);
    chk(frames - f0 == 3 + PLIM, "R5 quiet after busy abort", frames - f0, 3 + PLIM);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule